// File: doc/BRIEF.md
# Authentication Message Byte Assembler

The host feeds this block one byte per write. Each byte belongs to the input message of an authentication operation, such as a certificate signature check, master-key encryption, key derivation or one of the hash comparisons. The block knows which fields each operation expects, in which order, and whether each field arrives least-significant byte first or most-significant byte first. It places every incoming byte into a buffer so that a later reader can fetch any byte by field number and byte significance. The reader does not need to know the order in which the byte arrived.

The block keeps a count of the bytes written since the last pointer rewind or command. When the host issues a command, the block compares that count with the exact message length for the selected operation. It then reports whether the message was complete and well-formed. For the two operations with a variable-length field, the length of that field comes from a value that the host programs. The fixed fields that follow it shift with that value. If the host writes more bytes than the buffer holds, the extra bytes are dropped and a sticky overflow flag is raised.

Top module: `amb_assembler`

## Requirements
- R1: After reset, `msg_chk`, `msg_ok` and `overflow` are 0 and the write pointer is 0.
- R2: Only bits 7:0 of `wr_data` are stored. Bits 31:8 have no effect on any stored byte.
- R3: A write that arrives while `BUF_BYTES` bytes are already held is dropped and sets `overflow`. `overflow` stays set through commands and is cleared only by `rewind`. A command judged while any byte was dropped reports `msg_ok` = 0.
- R4: The read port addresses bytes by significance (`rd_sig` 0 = least significant byte of the field). In a least-significant-first field, the k-th byte written has significance k. In a most-significant-first field of length L, the k-th byte written has significance L-1-k. Only field 0 of operations 0 and 1 (the signature) is least-significant first.
- R5: Field index = position in the sequence. The sequences by `op_sel` are:
  - 0: signature 384, receiver ID 5, modulus 128, exponent 3, reserved 2 (total 522)
  - 1: signature 384, SRM body var_len
  - 2: modulus 128, exponent 3
  - 3: rrx 8, RxCaps 3
  - 4: H' 32
  - 5: L' 32
  - 6: V' 16, ID list var_len, RxInfo 2, seq_num_V 3
  - 7: M' 32, StreamID_Type 2, seq_num_M 3
- R6: For operations 1 and 6, the variable field is `var_len` bytes long. The fields that follow it begin right after it, so their positions depend on `var_len`.
- R7: Two cycles after a `cmd_go` pulse is driven (one cycle after the clock edge that samples it), `msg_chk` is 1. `msg_ok` is 1 exactly when the byte count equals the operation's total length and no byte was dropped. The write pointer returns to 0.
- R8: A write in the same cycle as `cmd_go` is stored and counted in that judgement before the pointer resets. A write in the same cycle as `rewind` is dropped. `rewind` also clears `msg_chk` and `msg_ok`.
- R9: `rd_data` returns the addressed byte one cycle after `rd_field`/`rd_sig` are sampled. It is 0 when the field index is beyond the operation's field count, when `rd_sig` is not less than the field length, or when the address lies beyond the buffer.
- R10: Any write without `cmd_go` clears `msg_chk` and `msg_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_sel | input | 3 | Operation whose message is being assembled |
| var_len | input | VLEN_W | Length of the variable field for operations 1 and 6 |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 32 | Write word; bits 7:0 carry the byte |
| rewind | input | 1 | Pointer rewind pulse; clears overflow and result |
| cmd_go | input | 1 | Command issue pulse; judges the message and resets the pointer |
| rd_field | input | 3 | Field index for the read port |
| rd_sig | input | SIG_W | Byte significance within the field |
| rd_data | output | 8 | Read byte, one cycle latency |
| msg_chk | output | 1 | A judgement is being shown |
| msg_ok | output | 1 | The judged message was complete and well-formed |
| overflow | output | 1 | Sticky dropped-byte flag |

## Verification
The final byte write and the command can fall in the same cycle. Pointer rewind and a byte write can also coincide. The bench provokes the first case by writing 31 bytes of a 32-byte hash message and then raising `wr_en` and `cmd_go` together. It judges the result by `msg_ok` being 1, and then by a follow-up 32-byte message also passing, which shows the pointer restarted at 0. For the second case, the bench raises `rewind` together with a write and then sends a full 11-byte key-derivation message. That message passes only if the coinciding byte was not counted.

// File: rtl/amb_pkg.sv
package amb_pkg;
  typedef logic [15:0] len_t;
  typedef logic [2:0]  fld_t;

  typedef enum logic [2:0] {
    OP_CERT = 3'd0,
    OP_SRM  = 3'd1,
    OP_MKEY = 3'd2,
    OP_KD   = 3'd3,
    OP_HH   = 3'd4,
    OP_LH   = 3'd5,
    OP_VH   = 3'd6,
    OP_MH   = 3'd7
  } op_e;

  localparam int MAX_FLD = 5;

  // Length in bytes of field idx of an operation; 0 past its last field.
  function automatic len_t fld_len(op_e op, fld_t idx, len_t vlen);
    len_t l;
    l = '0;
    unique case (op)
      OP_CERT: case (idx)
        3'd0: l = 16'd384;
        3'd1: l = 16'd5;
        3'd2: l = 16'd128;
        3'd3: l = 16'd3;
        3'd4: l = 16'd2;
        default: l = '0;
      endcase
      OP_SRM: case (idx)
        3'd0: l = 16'd384;
        3'd1: l = vlen;
        default: l = '0;
      endcase
      OP_MKEY: case (idx)
        3'd0: l = 16'd128;
        3'd1: l = 16'd3;
        default: l = '0;
      endcase
      OP_KD: case (idx)
        3'd0: l = 16'd8;
        3'd1: l = 16'd3;
        default: l = '0;
      endcase
      OP_HH, OP_LH: l = (idx == 3'd0) ? 16'd32 : 16'd0;
      OP_VH: case (idx)
        3'd0: l = 16'd16;
        3'd1: l = vlen;
        3'd2: l = 16'd2;
        3'd3: l = 16'd3;
        default: l = '0;
      endcase
      OP_MH: case (idx)
        3'd0: l = 16'd32;
        3'd1: l = 16'd2;
        3'd2: l = 16'd3;
        default: l = '0;
      endcase
    endcase
    return l;
  endfunction

  // Only the signature field arrives least-significant byte first.
  function automatic logic fld_lsb(op_e op, fld_t idx);
    return (op == OP_CERT || op == OP_SRM) && idx == 3'd0;
  endfunction

  // Buffer offset of field idx: the sum of all earlier field lengths.
  function automatic len_t fld_base(op_e op, fld_t idx, len_t vlen);
    len_t b;
    b = '0;
    for (int i = 0; i < MAX_FLD; i++)
      if (i < int'(idx)) b = b + fld_len(op, fld_t'(i), vlen);
    return b;
  endfunction

  function automatic len_t msg_total(op_e op, len_t vlen);
    return fld_base(op, fld_t'(MAX_FLD), vlen);
  endfunction

  // Buffer address of the byte at arrival position pos. Bytes past the
  // message end are placed linearly.
  function automatic len_t place(op_e op, len_t vlen, len_t pos);
    len_t b, l, r;
    logic hit;
    b = '0;
    r = pos;
    hit = 1'b0;
    for (int i = 0; i < MAX_FLD; i++) begin
      l = fld_len(op, fld_t'(i), vlen);
      if (!hit && pos >= b && pos < b + l) begin
        hit = 1'b1;
        r = fld_lsb(op, fld_t'(i)) ? pos : b + (l - 16'd1 - (pos - b));
      end
      b = b + l;
    end
    return r;
  endfunction
endpackage

// File: rtl/amb_wr_ptr.sv
module amb_wr_ptr #(
  parameter int BUF_BYTES = 640,
  parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             cmd_go,
  input  logic             rewind,
  output logic [CNT_W-1:0] wcnt,
  output logic             fire,
  output logic             drop,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BUF_BYTES);

  logic full;
  assign full = (wcnt == FULL_CNT);
  assign fire = wr_en && !rewind && !full;
  assign drop = wr_en && !rewind && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wcnt <= '0;
    else if (rewind || cmd_go) wcnt <= '0;
    else if (fire)             wcnt <= wcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      overflow <= 1'b0;
    else if (rewind) overflow <= 1'b0;
    else if (drop)   overflow <= 1'b1;
  end

  // R3: the count never passes the buffer size
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= FULL_CNT);
  // R3: a dropped byte raises the sticky flag
  p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overflow);
  // R3: rewind clears the flag
  p_ovf_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> !overflow);
  // R7: command or rewind returns the pointer to 0
  p_ptr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go || rewind) |=> wcnt == '0);
endmodule

// File: rtl/amb_store.sv
module amb_store
  import amb_pkg::*;
#(
  parameter int DEPTH = 640,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  len_t       waddr,
  input  logic [7:0] wbyte,
  input  logic       rd_en,
  input  len_t       raddr,
  output logic [7:0] rd_data
);
  localparam len_t DEPTH_L = len_t'(DEPTH);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk)
    if (we && waddr < DEPTH_L) mem[waddr[AW-1:0]] <= wbyte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= (rd_en && raddr < DEPTH_L) ? mem[raddr[AW-1:0]] : 8'h00;
  end

  // R9: an out-of-range read returns zero
  p_rd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rd_data == 8'h00);
endmodule

// File: rtl/amb_judge.sv
module amb_judge
  import amb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic cmd_go,
  input  logic rewind,
  input  logic fire,
  input  logic drop,
  input  logic overflow,
  input  len_t count,
  input  len_t total,
  output logic msg_chk,
  output logic msg_ok
);
  len_t cnt_eff;
  logic good;

  // a byte written together with the command still counts (R8)
  assign cnt_eff = count + len_t'(fire);
  assign good    = !overflow && !drop && (cnt_eff == total);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_chk <= 1'b0;
      msg_ok  <= 1'b0;
    end else if (rewind) begin
      msg_chk <= 1'b0;
      msg_ok  <= 1'b0;
    end else if (cmd_go) begin
      msg_chk <= 1'b1;
      msg_ok  <= good;
    end else if (wr_en) begin
      msg_chk <= 1'b0;
      msg_ok  <= 1'b0;
    end
  end

  // R7: a command always produces a judgement
  p_cmd_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go && !rewind |=> msg_chk);
  // R3: a dropped byte fails the judgement
  p_drop_fails_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go && !rewind && drop |=> !msg_ok);
  // R10: a plain write withdraws the judgement
  p_wr_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !cmd_go && !rewind |=> !msg_chk && !msg_ok);
  // R8: rewind withdraws the judgement
  p_rewind_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> !msg_chk);
endmodule

// File: rtl/amb_assembler.sv
module amb_assembler
  import amb_pkg::*;
#(
  parameter int BUF_BYTES = 640,
  parameter int VLEN_W    = 10,
  parameter int SIG_W     = 10,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_sel,
  input  logic [VLEN_W-1:0] var_len,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rewind,
  input  logic              cmd_go,
  input  logic [2:0]        rd_field,
  input  logic [SIG_W-1:0]  rd_sig,
  output logic [7:0]        rd_data,
  output logic              msg_chk,
  output logic              msg_ok,
  output logic              overflow
);
  op_e  op;
  len_t vlen;
  assign op   = op_e'(op_sel);
  assign vlen = len_t'(var_len);

  // R2: upper write bits are ignored
  logic [23:0] unused_hi;
  assign unused_hi = wr_data[31:8];

  logic [CNT_W-1:0] wcnt;
  logic fire, drop;

  amb_wr_ptr #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd_go(cmd_go), .rewind(rewind),
    .wcnt(wcnt), .fire(fire), .drop(drop), .overflow(overflow)
  );

  // placement of the current byte and the read lookup
  len_t wpos, waddr, rlen, raddr, total;
  logic rd_en;
  assign wpos  = len_t'(wcnt);
  assign waddr = place(op, vlen, wpos);
  assign total = msg_total(op, vlen);
  assign rlen  = fld_len(op, rd_field, vlen);
  assign rd_en = len_t'(rd_sig) < rlen;
  assign raddr = fld_base(op, rd_field, vlen) + len_t'(rd_sig);

  amb_store #(.DEPTH(BUF_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .we(fire), .waddr(waddr), .wbyte(wr_data[7:0]),
    .rd_en(rd_en), .raddr(raddr), .rd_data(rd_data)
  );

  amb_judge u_judge (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd_go(cmd_go), .rewind(rewind),
    .fire(fire), .drop(drop), .overflow(overflow), .count(wpos), .total(total),
    .msg_chk(msg_chk), .msg_ok(msg_ok)
  );

  // R5: a byte inside the message lands inside the message region
  p_place_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && wpos < total |-> waddr < total);
endmodule

// File: tb/amb_assembler_test.sv
`timescale 1ns/1ps
module amb_assembler_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] op_sel = '0;
  logic [9:0] var_len = '0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic rewind = 1'b0;
  logic cmd_go = 1'b0;
  logic [2:0] rd_field = '0;
  logic [9:0] rd_sig = '0;
  logic [7:0] rd_data;
  logic msg_chk, msg_ok, overflow;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  amb_assembler uut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .var_len(var_len),
    .wr_en(wr_en), .wr_data(wr_data), .rewind(rewind), .cmd_go(cmd_go),
    .rd_field(rd_field), .rd_sig(rd_sig), .rd_data(rd_data),
    .msg_chk(msg_chk), .msg_ok(msg_ok), .overflow(overflow)
  );

  // {op, var_len, byte count, pad, expected msg_ok}
  localparam logic [31:0] VEC [14] = '{
    {3'd0, 10'd0,   11'd522, 7'd0, 1'b1},
    {3'd0, 10'd0,   11'd521, 7'd0, 1'b0},
    {3'd1, 10'd100, 11'd484, 7'd0, 1'b1},
    {3'd1, 10'd100, 11'd485, 7'd0, 1'b0},
    {3'd2, 10'd0,   11'd131, 7'd0, 1'b1},
    {3'd3, 10'd0,   11'd11,  7'd0, 1'b1},
    {3'd3, 10'd0,   11'd10,  7'd0, 1'b0},
    {3'd4, 10'd0,   11'd32,  7'd0, 1'b1},
    {3'd5, 10'd0,   11'd33,  7'd0, 1'b0},
    {3'd6, 10'd10,  11'd31,  7'd0, 1'b1},
    {3'd6, 10'd0,   11'd21,  7'd0, 1'b1},
    {3'd7, 10'd0,   11'd37,  7'd0, 1'b1},
    {3'd7, 10'd0,   11'd36,  7'd0, 1'b0},
    {3'd1, 10'd300, 11'd640, 7'd0, 1'b0}
  };

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 0; cmd_go = 0; rewind = 0;
  endtask

  task automatic wr(int i);
    @(negedge clk);
    wr_en = 1; cmd_go = 0; rewind = 0;
    wr_data = {8'(i * 13), 16'hBEEF, pat(i)};
  endtask

  task automatic start(int op, int vl);
    @(negedge clk);
    op_sel = 3'(op); var_len = 10'(vl);
    wr_en = 0; cmd_go = 0; rewind = 1;
    idle();
  endtask

  task automatic send(int n);
    for (int i = 0; i < n; i++) wr(i);
    idle();
  endtask

  task automatic issue();
    @(negedge clk);
    wr_en = 0; rewind = 0; cmd_go = 1;
    idle();
  endtask

  task automatic rd(int f, int s, output logic [7:0] v);
    @(negedge clk);
    rd_field = 3'(f); rd_sig = 10'(s);
    @(negedge clk);
    v = rd_data;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1 msg_chk", int'(msg_chk), 0);
    check("R1 msg_ok", int'(msg_ok), 0);
    check("R1 overflow", int'(overflow), 0);

    // R5 R6 R7: table of message lengths per operation
    for (int k = 0; k < 14; k++) begin
      start(int'(VEC[k][31:29]), int'(VEC[k][28:19]));
      send(int'(VEC[k][18:8]));
      issue();
      check("R7 msg_chk", int'(msg_chk), 1);
      check("R5 msg_ok vector", int'(msg_ok), int'(VEC[k][0]));
    end

    // R2 R4: key-derivation fields, most-significant first
    start(3, 0);
    send(11);
    for (int s = 0; s < 8; s++) begin
      rd(0, s, v);
      check("R4 rrx byte order R2", int'(v), int'(pat(7 - s)));
    end
    for (int s = 0; s < 3; s++) begin
      rd(1, s, v);
      check("R4 caps byte order", int'(v), int'(pat(10 - s)));
    end

    // R4 R9: certificate, signature least-significant first
    start(0, 0);
    send(522);
    rd(0, 0, v);   check("R4 sig lsb first", int'(v), int'(pat(0)));
    rd(0, 383, v); check("R4 sig top byte", int'(v), int'(pat(383)));
    rd(2, 127, v); check("R4 modulus msb", int'(v), int'(pat(389)));
    rd(4, 0, v);   check("R4 reserved lsb", int'(v), int'(pat(521)));
    rd(4, 2, v);   check("R9 sig past field", int'(v), 0);
    rd(5, 0, v);   check("R9 field past op", int'(v), 0);

    // R6: variable ID list shifts trailing fields
    start(6, 4);
    send(25);
    rd(1, 0, v); check("R6 id list lsb", int'(v), int'(pat(19)));
    rd(2, 1, v); check("R6 rxinfo msb", int'(v), int'(pat(20)));
    rd(3, 0, v); check("R6 seq lsb", int'(v), int'(pat(24)));

    // R3: overflow drops, sticky through a command, rewind clears
    start(4, 0);
    send(641);
    check("R3 overflow set", int'(overflow), 1);
    rd(0, 0, v); check("R3 dropped byte no effect", int'(v), int'(pat(31)));
    issue();
    check("R3 msg_ok after drop", int'(msg_ok), 0);
    check("R3 overflow sticky", int'(overflow), 1);
    start(4, 0);
    check("R3 rewind clears", int'(overflow), 0);

    // R8: last byte together with the command
    start(4, 0);
    for (int i = 0; i < 31; i++) wr(i);
    @(negedge clk);
    wr_en = 1; cmd_go = 1; wr_data = {24'h0, pat(31)};
    idle();
    check("R8 write with cmd counted", int'(msg_ok), 1);
    wr(0);
    idle();
    check("R10 write clears chk", int'(msg_chk), 0);
    check("R10 write clears ok", int'(msg_ok), 0);
    for (int i = 1; i < 32; i++) wr(i);
    idle();
    issue();
    check("R7 pointer reset after cmd", int'(msg_ok), 1);

    // R8: write together with rewind is dropped
    @(negedge clk);
    op_sel = 3'd3; var_len = '0;
    wr_en = 1; rewind = 1; wr_data = 32'h0000_00FF;
    idle();
    send(11);
    issue();
    check("R8 rewind drops write", int'(msg_ok), 1);

    // R7: command with no bytes
    start(2, 0);
    issue();
    check("R7 empty chk", int'(msg_chk), 1);
    check("R7 empty ok", int'(msg_ok), 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule